// File: doc/BRIEF.md
# Quad-Tree Activity Block Partitioner

This block splits each 8x8 tile of an image into square regions of uniform activity. Pixels of one tile arrive one per handshake in hierarchical order. A cascade of three identical four-input reducers produces the maximum, minimum and sum of every 2x2, 4x4 and 8x8 region. The spread of each region (its maximum minus its minimum, a morphological gradient) is compared against a limit that is fixed when the block is built. The largest region that is flat enough is kept. For every pixel, in arrival order, the block then returns the size code of the region that covers it and the truncated mean of that region.

Operation alternates between two states. In `ST_FILL` the block accepts pixels and feeds the reducers. After the 64th pixel is accepted it takes the transition FILL_DONE to `ST_EMIT`. In `ST_EMIT` input is refused and the 64 results are offered. After the 64th result is taken it takes the transition EMIT_DONE back to `ST_FILL`.

Top module: `qtree_block_sizer`

## Requirements
- R1: After reset the block is in `ST_FILL`: `in_ready` is 1 and `out_valid` is 0.
- R2: Exactly 64 pixels are accepted per tile. After the 64th, `in_ready` is 0 and `out_valid` is 1 until 64 results have been taken, after which `in_ready` returns to 1 and `out_valid` to 0. The two are never high together.
- R3: When the 8x8 spread and every 4x4 spread are all at most `GRAD_LIMIT`, every pixel of the tile gets code 3 and mean = (tile sum) >> 6.
- R4: Otherwise, a 4x4 quadrant whose own spread and whose four 2x2 spreads are all at most `GRAD_LIMIT` gets code 2 for its pixels and mean = (quadrant sum) >> 4.
- R5: Every remaining pixel gets code 1 and mean = (2x2 group sum) >> 2. Code 0 is never produced.
- R6: A spread equal to `GRAD_LIMIT` counts as flat. A spread of `GRAD_LIMIT`+1 forces a split.
- R7: Arrival index bits: [1:0] give the pixel within its 2x2 group, [3:2] the group within its quadrant, [5:4] the quadrant within the tile. Results leave in arrival order, and all four pixels of a 2x2 group carry the same code and mean.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_code` and `out_mean` hold their values.
- R9: A cycle with `in_valid` low accepts nothing, whatever value is on `in_pixel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Block is filling and takes the pixel |
| in_pixel | input | PIX_W | Unsigned pixel value |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_code | output | 2 | Region size code: 1 = 2x2, 2 = 4x4, 3 = 8x8 |
| out_mean | output | PIX_W | Truncated mean of the covering region |

## Verification
A reducer counter that is out of phase mixes pixels from neighbouring groups. This shows up in the first tile as wrong means and as codes that change inside a 2x2 group. A wrong stored flag or mean appears only when the emit position reaches the affected group, so the bench compares every one of the 64 results of every tile. A fill or emit counter that is off by one shifts the phase boundary. This is visible at once as a 65th accepted pixel or a missing result, and it corrupts every tile after it.

// File: rtl/qtree_pkg.sv
package qtree_pkg;
    localparam int TILE_PIX  = 64;
    localparam int POS_W     = 6;
    localparam int GROUPS    = 16;
    localparam int QUADS     = 4;
    localparam int LEVELS    = 3;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_2X2  = 2'd1,
        SZ_4X4  = 2'd2,
        SZ_8X8  = 2'd3
    } blk_size_e;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_EMIT = 1'b1
    } phase_e;
endpackage

// File: rtl/quad_reducer.sv
module quad_reducer #(
    parameter int VAL_W = 8,
    parameter int SUM_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [VAL_W-1:0] in_max,
    input  logic [VAL_W-1:0] in_min,
    input  logic [SUM_W-1:0] in_sum,
    output logic             out_vld,
    output logic [VAL_W-1:0] out_max,
    output logic [VAL_W-1:0] out_min,
    output logic [SUM_W-1:0] out_sum
);
    logic [1:0]       cnt_q;
    logic [VAL_W-1:0] acc_max_q, acc_min_q;
    logic [SUM_W-1:0] acc_sum_q;
    logic             first;

    always_comb begin
        first   = (cnt_q == 2'd0);
        out_max = (first || in_max > acc_max_q) ? in_max : acc_max_q;
        out_min = (first || in_min < acc_min_q) ? in_min : acc_min_q;
        out_sum = (first ? '0 : acc_sum_q) + in_sum;
        out_vld = in_vld && (cnt_q == 2'd3);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            acc_max_q <= '0;
            acc_min_q <= '0;
            acc_sum_q <= '0;
        end else if (in_vld) begin
            cnt_q     <= cnt_q + 2'd1;
            acc_max_q <= out_max;
            acc_min_q <= out_min;
            acc_sum_q <= out_sum;
        end
    end
endmodule

// File: rtl/blk_size_select.sv
module blk_size_select
    import qtree_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [3:0]       grp,
    input  logic             flat8,
    input  logic [QUADS-1:0] flat4,
    input  logic [PIX_W-1:0] mean8,
    input  logic [PIX_W-1:0] mean4 [QUADS],
    input  logic [PIX_W-1:0] mean2 [GROUPS],
    output blk_size_e        code,
    output logic [PIX_W-1:0] mean
);
    always_comb begin
        if (flat8) begin
            code = SZ_8X8;
            mean = mean8;
        end else if (flat4[grp[3:2]]) begin
            code = SZ_4X4;
            mean = mean4[grp[3:2]];
        end else begin
            code = SZ_2X2;
            mean = mean2[grp];
        end
    end
endmodule

// File: rtl/qtree_block_sizer.sv
module qtree_block_sizer
    import qtree_pkg::*;
#(
    parameter int PIX_W      = 8,
    parameter int GRAD_LIMIT = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_pixel,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [1:0]       out_code,
    output logic [PIX_W-1:0] out_mean
);
    localparam int SUM_W = PIX_W + 2 * LEVELS;
    localparam logic [PIX_W-1:0] LIMIT_V = PIX_W'(GRAD_LIMIT);

    phase_e            state_q, state_d;
    logic [POS_W-1:0]  pos_q;
    logic              take_in, take_out, last_pos;

    logic             lv_vld [0:LEVELS];
    logic [PIX_W-1:0] lv_max [0:LEVELS];
    logic [PIX_W-1:0] lv_min [0:LEVELS];
    logic [SUM_W-1:0] lv_sum [0:LEVELS];
    logic             grd_ok [1:LEVELS];

    logic [GROUPS-1:0] flat2_q;
    logic [QUADS-1:0]  flat4_q;
    logic              flat8_q;
    logic [PIX_W-1:0]  mean2_q [GROUPS];
    logic [PIX_W-1:0]  mean4_q [QUADS];
    logic [PIX_W-1:0]  mean8_q;
    logic              quad_flat_now;
    blk_size_e         sel_code;

    // level 0 is the raw pixel stream
    assign lv_vld[0] = take_in;
    assign lv_max[0] = in_pixel;
    assign lv_min[0] = in_pixel;
    assign lv_sum[0] = SUM_W'(in_pixel);

    generate
        for (genvar k = 1; k <= LEVELS; k++) begin : g_level
            quad_reducer #(.VAL_W(PIX_W), .SUM_W(SUM_W)) u_red (
                .clk     (clk),
                .rst     (rst),
                .in_vld  (lv_vld[k-1]),
                .in_max  (lv_max[k-1]),
                .in_min  (lv_min[k-1]),
                .in_sum  (lv_sum[k-1]),
                .out_vld (lv_vld[k]),
                .out_max (lv_max[k]),
                .out_min (lv_min[k]),
                .out_sum (lv_sum[k])
            );
            assign grd_ok[k] = (lv_max[k] - lv_min[k]) <= LIMIT_V;
        end
    endgenerate

    // state register and position counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take_in || take_out) pos_q <= pos_q + 1'b1;
        end
    end

    always_comb begin
        last_pos = (pos_q == POS_W'(TILE_PIX - 1));
        state_d  = state_q;
        unique case (state_q)
            ST_FILL: if (take_in  && last_pos) state_d = ST_EMIT;
            ST_EMIT: if (take_out && last_pos) state_d = ST_FILL;
        endcase
    end

    // output process
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_FILL: in_ready  = 1'b1;
            ST_EMIT: out_valid = 1'b1;
        endcase
        take_in  = in_valid && in_ready;
        take_out = out_valid && out_ready;
        out_code = sel_code;
    end

    // quadrant flatness including the 2x2 group finishing this cycle
    assign quad_flat_now = grd_ok[2] && grd_ok[1] && (&flat2_q[{pos_q[5:4], 2'b00} +: 3]);

    always_ff @(posedge clk) begin
        if (rst) begin
            flat2_q <= '0;
            flat4_q <= '0;
            flat8_q <= 1'b0;
        end else begin
            if (lv_vld[1]) flat2_q[pos_q[5:2]] <= grd_ok[1];
            if (lv_vld[2]) flat4_q[pos_q[5:4]] <= quad_flat_now;
            if (lv_vld[3]) flat8_q <= grd_ok[3] && quad_flat_now && (&flat4_q[2:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (lv_vld[1]) mean2_q[pos_q[5:2]] <= PIX_W'(lv_sum[1] >> 2);
        if (lv_vld[2]) mean4_q[pos_q[5:4]] <= PIX_W'(lv_sum[2] >> 4);
        if (lv_vld[3]) mean8_q <= PIX_W'(lv_sum[3] >> 6);
    end

    blk_size_select #(.PIX_W(PIX_W)) u_sel (
        .grp   (pos_q[5:2]),
        .flat8 (flat8_q),
        .flat4 (flat4_q),
        .mean8 (mean8_q),
        .mean4 (mean4_q),
        .mean2 (mean2_q),
        .code  (sel_code),
        .mean  (out_mean)
    );
endmodule

// File: rtl/qtree_block_sizer_chk.sv
module qtree_block_sizer_chk #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [1:0]       out_code,
    input logic [PIX_W-1:0] out_mean
);
    logic [5:0] acc_cnt, out_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_cnt <= '0;
            out_cnt <= '0;
        end else begin
            if (in_valid && in_ready)   acc_cnt <= acc_cnt + 6'd1;
            if (out_valid && out_ready) out_cnt <= out_cnt + 6'd1;
        end
    end

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid)); // R2

    AST_FILL_LEN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && acc_cnt == 6'd63) |=> (!in_ready && out_valid)); // R2

    AST_DRAIN_LEN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_cnt == 6'd63) |=> (in_ready && !out_valid)); // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_mean))); // R8

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_code != 2'd0)); // R5

    AST_GROUP_SAME: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_cnt[1:0] != 2'b11)
        |=> (out_code == $past(out_code) && out_mean == $past(out_mean))); // R7
endmodule

bind qtree_block_sizer qtree_block_sizer_chk #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_code  (out_code),
    .out_mean  (out_mean)
);

// File: tb/qtree_block_sizer_tb.sv
module qtree_block_sizer_tb;
    localparam int THD = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_pixel = '0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [1:0] out_code;
    logic [7:0] out_mean;

    int  n_err = 0;
    int  n_chk = 0;
    bit  finished = 0;
    int  px      [64];
    int  e_code  [64];
    int  e_mean  [64];

    always #4 clk = ~clk;

    qtree_block_sizer #(.PIX_W(8), .GRAD_LIMIT(THD)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_pixel(in_pixel), .out_valid(out_valid), .out_ready(out_ready),
        .out_code(out_code), .out_mean(out_mean)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model built from the requirements
    task automatic build_ref();
        int  s2 [16]; bit f2 [16];
        int  s4 [4];  bit f4 [4];
        int  s8;      bit f8;
        int  mx, mn, s;
        for (int g = 0; g < 16; g++) begin
            mx = 0; mn = 255; s = 0;
            for (int i = 0; i < 4; i++) begin
                if (px[g*4+i] > mx) mx = px[g*4+i];
                if (px[g*4+i] < mn) mn = px[g*4+i];
                s += px[g*4+i];
            end
            s2[g] = s; f2[g] = (mx - mn) <= THD;
        end
        for (int q = 0; q < 4; q++) begin
            mx = 0; mn = 255; s = 0;
            for (int i = 0; i < 16; i++) begin
                if (px[q*16+i] > mx) mx = px[q*16+i];
                if (px[q*16+i] < mn) mn = px[q*16+i];
                s += px[q*16+i];
            end
            s4[q] = s;
            f4[q] = ((mx - mn) <= THD) && f2[q*4] && f2[q*4+1] && f2[q*4+2] && f2[q*4+3];
        end
        mx = 0; mn = 255; s = 0;
        for (int i = 0; i < 64; i++) begin
            if (px[i] > mx) mx = px[i];
            if (px[i] < mn) mn = px[i];
            s += px[i];
        end
        s8 = s;
        f8 = ((mx - mn) <= THD) && f4[0] && f4[1] && f4[2] && f4[3];
        for (int j = 0; j < 64; j++) begin
            if (f8)             begin e_code[j] = 3; e_mean[j] = s8 >> 6; end
            else if (f4[j/16])  begin e_code[j] = 2; e_mean[j] = s4[j/16] >> 4; end
            else                begin e_code[j] = 1; e_mean[j] = s2[j/4] >> 2; end
        end
    endtask

    task automatic run_tile(input string tag);
        int  k;
        bit  stalled;
        int  pc, pm;
        string rq;
        build_ref();
        k = 0;
        while (k < 64) begin
            @(negedge clk);
            in_valid = ($urandom % 4) != 0;
            in_pixel = in_valid ? 8'(px[k]) : 8'($urandom);   // R9 garbage on idle cycles
            if (in_valid && in_ready) k++;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(!in_ready && out_valid, {"R2 fill end ", tag}, {in_ready, out_valid}, 1);
        k = 0;
        stalled = 0;
        while (k < 64) begin
            if (stalled) check(out_valid && out_code == pc && out_mean == pm,
                               {"R8 stall ", tag}, out_mean, pm);
            out_ready = ($urandom % 3) != 0;
            if (out_valid && out_ready) begin
                rq = (e_code[k] == 3) ? "R3" : (e_code[k] == 2) ? "R4" : "R5";
                check(out_code == e_code[k], {rq, " R7 code ", tag}, out_code, e_code[k]);
                check(out_mean == e_mean[k], {rq, " R7 mean ", tag}, out_mean, e_mean[k]);
                k++;
            end
            stalled = out_valid && !out_ready;
            pc = out_code; pm = out_mean;
            @(posedge clk);
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(in_ready && !out_valid, {"R2 drain end ", tag}, {in_ready, out_valid}, 2);
    endtask

    initial begin
        int seed_sink;
        int base, rng;
        int ranges [6];
        seed_sink = $urandom(32'd4242);
        ranges = '{0, THD/2, THD, THD+3, 60, 255};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready && !out_valid, "R1 reset state", {in_ready, out_valid}, 2);

        for (int i = 0; i < 64; i++) px[i] = 100;
        run_tile("flat");
        for (int i = 0; i < 64; i++) px[i] = (i % 2) ? 50 + THD : 50;   // R6 spread exactly THD
        run_tile("R6 at limit");
        for (int i = 0; i < 64; i++) px[i] = 80;
        px[37] = 80 + THD + 1;                                          // R6 one above limit
        run_tile("R6 above limit");
        for (int i = 0; i < 64; i++) px[i] = (i % 2) ? 250 : 3;
        run_tile("busy");
        for (int i = 0; i < 64; i++) px[i] = (i < 4) ? 200 : 10;        // R7 first group differs
        run_tile("R7 order");

        for (int t = 0; t < 10; t++) begin
            base = $urandom % 150;
            for (int q = 0; q < 4; q++) begin
                rng = ranges[$urandom % 6];
                for (int i = 0; i < 16; i++) begin
                    px[q*16+i] = base + ($urandom % (rng + 1));
                    if (px[q*16+i] > 255) px[q*16+i] = 255;
                end
            end
            run_tile("random");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL R2 watchdog actual=hung expected=progress");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule